// File: doc/BRIEF.md
# Protection Information Tuple Checker

The block verifies end-to-end protection information over a run of logical blocks that arrive as one byte stream. Each logical block is made of a fixed number of data bytes followed by a fixed number of metadata bytes, and somewhere in the metadata sits a protection tuple that holds a stored guard, a stored application tag and a stored reference tag. For every block the checker recomputes the guard CRC over the covered bytes, compares the application tag under a mask, and compares the reference tag with a running expected value. It then gives one result for the whole command.

A command begins with a one-cycle `cmd_start` pulse, which also captures the configuration: protection type (1, 2 or 3), guard format (16-bit guard with a 32-bit reference tag, or 64-bit guard with a 48-bit reference tag), tuple placement in the metadata, check enables, expected application tag and mask, starting reference tag and starting logical block address. Configuration conflicts are reported at once, before any byte is accepted. After that the bytes stream in. The command ends at the first failing block, or after the last block if all blocks pass. A one-cycle `done` pulse carries the final status.

Top module: `pi_tuple_checker`

## Requirements
- R1: For type 1 with reference checking enabled, the starting address masked to the reference tag width (low 32 bits in 16-bit format, low 48 bits in 64-bit format) must equal the starting reference tag. A mismatch ends the command at once with status invalid (4) and `dnr` high. A match lets the command run, whatever the address bits above the mask hold. Types 2 and 3 skip this comparison.
- R2: For type 3, a command with reference checking enabled ends at once with status invalid (4) and `dnr` low.
- R3: For types 1 and 2, a block whose stored application tag is 0xFFFF passes without any check.
- R4: For type 3, a block is exempt from checks only when its stored application tag is 0xFFFF and its stored reference tag is all ones at the format's width. A tag of 0xFFFF alone still gets checked.
- R5: Checks run in the order guard, then application tag, then reference tag. The first failure ends the command at the end of that block, and the stream is no longer accepted after it.
- R6: The application tag check passes when (stored AND mask) equals (expected AND mask). Differences in masked-out bits have no effect.
- R7: The expected reference tag starts at the supplied value and rises by one after every block for types 1 and 2. It is compared at the format's width.
- R8: With the tuple at the end of the metadata, the guard covers the data bytes and then the metadata bytes ahead of the tuple. With the tuple at the start, it covers the data bytes only.
- R9: 16-bit format: an 8-byte big-endian tuple (guard 2 bytes, application tag 2, reference tag 4), with a non-reflected CRC, polynomial 0x8BB7, initial value 0, no final inversion. 64-bit format: a 16-byte big-endian tuple (guard 8, application tag 2, reference tag 6), with a reflected CRC, polynomial 0x9A6C9329AC4BC9B5, initial value all ones, final inversion.
- R10: In 64-bit format, a guard failure on the first block of a command whose starting address is 0 and whose data bytes are all zero is forgiven; that block passes. The 16-bit format has no such exemption.
- R11: Status codes are 0 success, 1 guard, 2 application tag, 3 reference tag, 4 invalid. `done` is high for exactly one cycle per command. It follows the accepting edge of the last byte of a failing block, or of the last byte of a block sent with `in_last` high. `in_ready` is high only while a command is streaming. `dnr` is high only together with status 4.
- R12: Check enables are `cfg_chk[2]` guard, `cfg_chk[1]` application tag, `cfg_chk[0]` reference tag. A disabled check never causes a failure.
- R13: After reset `done` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Starts a command and captures the configuration (ignored while streaming) |
| cfg_type | input | 2 | Protection type 1, 2 or 3 |
| cfg_wide | input | 1 | 1: 64-bit guard / 48-bit reference tag; 0: 16-bit guard / 32-bit tag |
| cfg_tuple_end | input | 1 | 1: tuple at end of metadata; 0: at start |
| cfg_chk | input | 3 | Check enables: [2] guard, [1] application tag, [0] reference tag |
| cfg_app_tag | input | 16 | Expected application tag |
| cfg_app_mask | input | 16 | Application tag compare mask |
| cfg_start_ref | input | 48 | Reference tag expected for the first block |
| cfg_start_lba | input | 64 | Starting logical block address |
| in_valid | input | 1 | Byte valid |
| in_ready | output | 1 | Byte accepted when high with `in_valid` |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks that the current byte belongs to the final block |
| done | output | 1 | One-cycle end-of-command pulse |
| status | output | 3 | Final status, valid with `done` |
| dnr | output | 1 | Do-not-retry flag, valid with `done` |

## Verification
Several properties are checked on every cycle: the single-cycle width of `done`, the drop of `in_ready` at completion, the pairing of `dnr` with the invalid status, and the immediate invalid result for configuration conflicts of type 1 and type 3. The guard arithmetic, tuple placement, escape values, mask handling, reference tag progression, check priority and the zero-block exemption depend on whole blocks of data. Only the bench's scenarios show those, by building each block with its own CRC model and inserting faults at chosen blocks.

// File: rtl/pi_pkg.sv
package pi_pkg;
    typedef enum logic [2:0] {
        PI_OK      = 3'd0,
        PI_GUARD   = 3'd1,
        PI_APP     = 3'd2,
        PI_REF     = 3'd3,
        PI_INVALID = 3'd4
    } pi_status_e;

    localparam int CHK_GUARD = 2;
    localparam int CHK_APP   = 1;
    localparam int CHK_REF   = 0;

    localparam logic [15:0] POLY16     = 16'h8BB7;
    localparam logic [63:0] POLY64R    = 64'h9A6C9329AC4BC9B5;
    localparam logic [15:0] APP_ESCAPE = 16'hFFFF;
endpackage

// File: rtl/pi_guard_step.sv
// One byte of guard CRC update; W selects the variant (16 normal, 64 reflected).
module pi_guard_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] crc_i,
    input  logic [7:0]   byte_i,
    output logic [W-1:0] crc_o
);
    import pi_pkg::*;

    generate
        if (W == 64) begin : g_reflected
            always_comb begin
                crc_o = crc_i;
                for (int i = 0; i < 8; i++) begin
                    if (crc_o[0] ^ byte_i[i]) crc_o = (crc_o >> 1) ^ W'(POLY64R);
                    else                      crc_o = crc_o >> 1;
                end
            end
        end else begin : g_normal
            always_comb begin
                crc_o = crc_i;
                for (int i = 0; i < 8; i++) begin
                    if (crc_o[W-1] ^ byte_i[7-i]) crc_o = (crc_o << 1) ^ W'(POLY16);
                    else                          crc_o = crc_o << 1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pi_tag_eval.sv
// Per-block verdict from a captured tuple: escape, then guard, app tag, ref tag.
module pi_tag_eval (
    input  logic [127:0]              tup,
    input  logic                      wide,
    input  logic [1:0]                ptype,
    input  logic [2:0]                chk,
    input  logic [63:0]               guard_calc,
    input  logic [15:0]               exp_app,
    input  logic [15:0]               app_mask,
    input  logic [47:0]               exp_ref,
    output pi_pkg::pi_status_e        verdict
);
    import pi_pkg::*;

    logic [63:0] st_guard;
    logic [15:0] st_app;
    logic [47:0] st_ref;
    logic [47:0] want_ref;
    logic        ref_ones;
    logic        escape;

    always_comb begin
        st_guard = wide ? tup[127:64] : {48'b0, tup[63:48]};
        st_app   = wide ? tup[63:48]  : tup[47:32];
        st_ref   = wide ? tup[47:0]   : {16'b0, tup[31:0]};
        want_ref = wide ? exp_ref     : {16'b0, exp_ref[31:0]};
        ref_ones = wide ? (&tup[47:0]) : (&tup[31:0]);
        escape   = (st_app == APP_ESCAPE) && ((ptype != 2'd3) || ref_ones);

        if (escape)                                           verdict = PI_OK;
        else if (chk[CHK_GUARD] && (st_guard != guard_calc))  verdict = PI_GUARD;
        else if (chk[CHK_APP] && (((st_app ^ exp_app) & app_mask) != 16'h0))
                                                              verdict = PI_APP;
        else if (chk[CHK_REF] && (st_ref != want_ref))        verdict = PI_REF;
        else                                                  verdict = PI_OK;
    end
endmodule

// File: rtl/pi_tuple_checker.sv
module pi_tuple_checker #(
    parameter int DATA_BYTES = 8,
    parameter int META_BYTES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_start,
    input  logic [1:0]  cfg_type,
    input  logic        cfg_wide,
    input  logic        cfg_tuple_end,
    input  logic [2:0]  cfg_chk,
    input  logic [15:0] cfg_app_tag,
    input  logic [15:0] cfg_app_mask,
    input  logic [47:0] cfg_start_ref,
    input  logic [63:0] cfg_start_lba,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        done,
    output logic [2:0]  status,
    output logic        dnr
);
    import pi_pkg::*;

    localparam int BLK_BYTES = DATA_BYTES + META_BYTES;
    localparam int PW        = $clog2(BLK_BYTES);
    localparam logic [PW:0] DATA_L = (PW+1)'(DATA_BYTES);
    localparam logic [PW:0] META_L = (PW+1)'(META_BYTES);
    localparam logic [PW:0] LAST_L = (PW+1)'(BLK_BYTES - 1);

    typedef struct packed {
        logic          run;
        logic          wide;
        logic          tend;
        logic [1:0]    ptype;
        logic [2:0]    chk;
        logic [15:0]   app;
        logic [15:0]   mask;
        logic [47:0]   eref;
        logic          first;
        logic          lba0;
        logic          dzero;
        logic [PW-1:0] pos;
        logic [63:0]   crc;
        logic [127:0]  tup;
        logic          done;
        logic [2:0]    status;
        logic          dnr;
    } st_t;

    st_t q, n;

    // block geometry for the current command
    logic [PW:0]  tsz, pil, cov_end, tup_end, posx;
    logic         in_cov, in_tup;
    logic [127:0] tup_nx;
    logic [15:0]  c16;
    logic [63:0]  c64;
    logic [63:0]  guard_calc;
    logic [63:0]  lba_m;
    pi_status_e   verdict;

    pi_guard_step #(.W(16)) u_g16 (.crc_i(q.crc[15:0]), .byte_i(in_data), .crc_o(c16));
    pi_guard_step #(.W(64)) u_g64 (.crc_i(q.crc),       .byte_i(in_data), .crc_o(c64));

    always_comb begin
        tsz     = q.wide ? (PW+1)'(16) : (PW+1)'(8);
        pil     = q.tend ? (META_L - tsz) : '0;
        cov_end = DATA_L + pil;
        tup_end = cov_end + tsz;
        posx    = {1'b0, q.pos};
        in_cov  = posx < cov_end;
        in_tup  = (posx >= cov_end) && (posx < tup_end);
        tup_nx  = in_tup ? {q.tup[119:0], in_data} : q.tup;
        guard_calc = q.wide ? ~q.crc : {48'b0, q.crc[15:0]};
        lba_m   = cfg_wide ? {16'b0, cfg_start_lba[47:0]} : {32'b0, cfg_start_lba[31:0]};
    end

    pi_tag_eval u_eval (
        .tup        (tup_nx),
        .wide       (q.wide),
        .ptype      (q.ptype),
        .chk        (q.chk),
        .guard_calc (guard_calc),
        .exp_app    (q.app),
        .app_mask   (q.mask),
        .exp_ref    (q.eref),
        .verdict    (verdict)
    );

    always_comb begin
        n      = q;
        n.done = 1'b0;
        n.dnr  = 1'b0;
        if (!q.run) begin
            if (cmd_start) begin
                n.wide   = cfg_wide;
                n.tend   = cfg_tuple_end;
                n.ptype  = cfg_type;
                n.chk    = cfg_chk;
                n.app    = cfg_app_tag;
                n.mask   = cfg_app_mask;
                n.eref   = cfg_start_ref;
                n.lba0   = (cfg_start_lba == 64'h0);
                n.first  = 1'b1;
                n.dzero  = 1'b1;
                n.pos    = '0;
                n.crc    = cfg_wide ? '1 : '0;
                n.tup    = '0;
                if ((cfg_type == 2'd1) && cfg_chk[CHK_REF] && (lba_m != {16'b0, cfg_start_ref})) begin
                    n.done   = 1'b1;
                    n.status = PI_INVALID;
                    n.dnr    = 1'b1;
                end else if ((cfg_type == 2'd3) && cfg_chk[CHK_REF]) begin
                    n.done   = 1'b1;
                    n.status = PI_INVALID;
                end else begin
                    n.run = 1'b1;
                end
            end
        end else if (in_valid) begin
            n.tup = tup_nx;
            if (in_cov) n.crc = q.wide ? c64 : {48'b0, c16};
            if ((posx < DATA_L) && (in_data != 8'h0)) n.dzero = 1'b0;
            if (posx == LAST_L) begin
                if ((verdict != PI_OK) &&
                    !(verdict == PI_GUARD && q.wide && q.first && q.lba0 && n.dzero)) begin
                    n.done   = 1'b1;
                    n.status = verdict;
                    n.run    = 1'b0;
                end else if (in_last) begin
                    n.done   = 1'b1;
                    n.status = PI_OK;
                    n.run    = 1'b0;
                end else begin
                    n.pos   = '0;
                    n.crc   = q.wide ? '1 : '0;
                    n.tup   = '0;
                    n.dzero = 1'b1;
                    n.first = 1'b0;
                    if (q.ptype != 2'd3) n.eref = q.eref + 48'd1;
                end
            end else begin
                n.pos = q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign in_ready = q.run;
    assign done     = q.done;
    assign status   = q.status;
    assign dnr      = q.dnr;
endmodule

// File: rtl/pi_tuple_checker_sva.sv
module pi_tuple_checker_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_start,
    input logic [1:0]  cfg_type,
    input logic        cfg_wide,
    input logic [2:0]  cfg_chk,
    input logic [47:0] cfg_start_ref,
    input logic [63:0] cfg_start_lba,
    input logic        in_valid,
    input logic        in_ready,
    input logic        done,
    input logic [2:0]  status,
    input logic        dnr
);
    logic [47:0] lba_cut;
    logic        lba_bad;
    assign lba_cut = cfg_wide ? cfg_start_lba[47:0] : {16'b0, cfg_start_lba[31:0]};
    assign lba_bad = lba_cut != cfg_start_ref;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready); // R11
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status <= 3'd4)); // R11
    AST_DNR_ONLY_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dnr) |-> (status == 3'd4)); // R1
    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(cmd_start) || $past(in_valid && in_ready))); // R11
    AST_T1_LBA_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !in_ready && cfg_type == 2'd1 && cfg_chk[0] && lba_bad)
        |=> (done && status == 3'd4 && dnr)); // R1
    AST_T1_LBA_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !in_ready && cfg_type == 2'd1 && cfg_chk[0] && !lba_bad)
        |=> (in_ready && !done)); // R1
    AST_T3_REF_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !in_ready && cfg_type == 2'd3 && cfg_chk[0])
        |=> (done && status == 3'd4 && !dnr)); // R2
endmodule

bind pi_tuple_checker pi_tuple_checker_sva u_sva (.*);

// File: tb/pi_tuple_checker_tb.sv
module pi_tuple_checker_tb_top;
    localparam int DB = 8;
    localparam int MB = 16;
    localparam int BB = DB + MB;
    localparam logic [63:0] L0 = 64'hAB00_0000_0012_3400;
    localparam logic [47:0] R0 = 48'h00_0012_3400;
    localparam logic [15:0] EXP_APP = 16'hA5C3;
    localparam logic [15:0] MASK    = 16'hFF0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [1:0]  cfg_type = 2'd1;
    logic        cfg_wide = 1'b0;
    logic        cfg_tuple_end = 1'b0;
    logic [2:0]  cfg_chk = 3'b0;
    logic [15:0] cfg_app_tag = EXP_APP;
    logic [15:0] cfg_app_mask = MASK;
    logic [47:0] cfg_start_ref = R0;
    logic [63:0] cfg_start_lba = L0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h0;
    logic        in_last = 1'b0;
    logic        done;
    logic [2:0]  status;
    logic        dnr;

    int checks = 0;
    int errors = 0;
    bit got = 0;
    int done_cnt = 0;
    logic [2:0] got_st = 3'd0;
    logic got_dnr = 1'b0;

    always #10 clk = ~clk;

    pi_tuple_checker #(.DATA_BYTES(DB), .META_BYTES(MB)) dut_i (.*);

    always @(posedge clk) begin
        if (rst_n && done) begin
            got = 1;
            got_st = status;
            got_dnr = dnr;
            done_cnt++;
        end
    end

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc16(input logic [7:0] b [BB], input int n);
        logic [15:0] c = 16'h0;
        for (int i = 0; i < n; i++) begin
            c = c ^ {b[i], 8'h00};
            for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h8BB7) : (c << 1);
        end
        return c;
    endfunction

    function automatic logic [63:0] ref_crc64(input logic [7:0] b [BB], input int n);
        logic [63:0] c = '1;
        for (int i = 0; i < n; i++) begin
            c = c ^ {56'h0, b[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 64'h9A6C9329AC4BC9B5) : (c >> 1);
        end
        return ~c;
    endfunction

    // bad: 0 none, 1 guard, 2 app, 3 ref, 4 guard+app, 5 full escape w/ bad guard,
    //      6 masked-out app bits, 7 app 0xFFFF only w/ bad guard
    task automatic run_cmd(input logic [1:0] pt, input logic wd, input logic te,
                           input logic [2:0] ck, input int bad, input int bad_blk,
                           input int nblk, input logic zero0, input logic [63:0] lba,
                           input logic [2:0] est, input logic ednr, input string tag);
        logic [7:0]  bb [BB];
        logic [63:0] g;
        logic [15:0] ap;
        logic [47:0] rf;
        int tsz, off;
        tsz = wd ? 16 : 8;
        off = DB + (te ? (MB - tsz) : 0);
        got = 0;
        done_cnt = 0;
        @(negedge clk);
        cfg_type = pt; cfg_wide = wd; cfg_tuple_end = te; cfg_chk = ck;
        cfg_start_lba = lba; cfg_start_ref = R0; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        @(negedge clk);
        if (est == 3'd4) chk(got, {tag, " immediate done"}, int'(got), 1);
        for (int b = 0; b < nblk && !got; b++) begin
            for (int j = 0; j < DB; j++) bb[j] = (zero0 && b == 0) ? 8'h0 : 8'(b * 37 + j * 11 + 5);
            for (int j = 0; j < MB; j++) bb[DB + j] = 8'(j * 29 + b + 3);
            g  = wd ? ref_crc64(bb, off) : {48'h0, ref_crc16(bb, off)};
            ap = EXP_APP;
            rf = (pt == 2'd3) ? R0 : R0 + 48'(b);
            if (!wd) rf[47:32] = 16'h0;
            if (b == bad_blk) begin
                case (bad)
                    1: g = g ^ 64'h1;
                    2: ap = ap ^ 16'h0100;
                    3: rf = rf ^ 48'h1;
                    4: begin g = g ^ 64'h1; ap = ap ^ 16'h0100; end
                    5: begin
                        g = g ^ 64'h1; ap = 16'hFFFF;
                        rf = wd ? 48'hFFFF_FFFF_FFFF : 48'h0000_FFFF_FFFF;
                        if (pt != 2'd3) rf = rf ^ 48'h5;
                    end
                    6: ap = ap ^ 16'h00F0;
                    7: begin g = g ^ 64'h1; ap = 16'hFFFF; end
                    default: ;
                endcase
            end
            if (wd) begin
                for (int k = 0; k < 8; k++) bb[off + k] = g[63 - 8 * k -: 8];
                bb[off + 8] = ap[15:8];
                bb[off + 9] = ap[7:0];
                for (int k = 0; k < 6; k++) bb[off + 10 + k] = rf[47 - 8 * k -: 8];
            end else begin
                bb[off] = g[15:8];
                bb[off + 1] = g[7:0];
                bb[off + 2] = ap[15:8];
                bb[off + 3] = ap[7:0];
                for (int k = 0; k < 4; k++) bb[off + 4 + k] = rf[31 - 8 * k -: 8];
            end
            for (int j = 0; j < BB; j++) begin
                if (!got) begin
                    in_valid = 1'b1;
                    in_data  = bb[j];
                    in_last  = (b == nblk - 1);
                    @(negedge clk);
                end
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (4) @(negedge clk);
        chk(got_st == est, {tag, " status"}, int'(got_st), int'(est));
        chk(got_dnr == ednr, {tag, " dnr"}, int'(got_dnr), int'(ednr));
        chk(done_cnt == 1, {tag, " done pulses"}, done_cnt, 1);
        chk(in_ready == 1'b0, {tag, " ready low after done"}, int'(in_ready), 0);
    endtask

    typedef struct packed {
        logic [1:0] pt;
        logic       wd;
        logic       te;
        logic [2:0] ck;
        logic [2:0] bad;
        logic [1:0] bblk;
        logic [2:0] nb;
        logic [2:0] est;
    } vec_t;

    localparam vec_t VEC [13] = '{
        '{2'd1, 1'b0, 1'b1, 3'b111, 3'd0, 2'd0, 3'd3, 3'd0}, // R8 R9 R7 tuple at end, clean
        '{2'd1, 1'b0, 1'b0, 3'b111, 3'd1, 2'd1, 3'd3, 3'd1}, // R8 R9 guard error, tuple at start
        '{2'd2, 1'b1, 1'b1, 3'b111, 3'd2, 2'd2, 3'd3, 3'd2}, // R6 R9 app error, 64-bit
        '{2'd1, 1'b1, 1'b0, 3'b111, 3'd3, 2'd1, 3'd3, 3'd3}, // R7 R9 ref error, 64-bit
        '{2'd1, 1'b0, 1'b1, 3'b111, 3'd4, 2'd0, 3'd2, 3'd1}, // R5 guard wins over app
        '{2'd1, 1'b0, 1'b1, 3'b011, 3'd4, 2'd0, 3'd2, 3'd2}, // R12 R5 guard disabled, app reported
        '{2'd2, 1'b0, 1'b0, 3'b100, 3'd3, 2'd1, 3'd3, 3'd0}, // R12 bad ref ignored
        '{2'd1, 1'b1, 1'b1, 3'b111, 3'd5, 2'd1, 3'd3, 3'd0}, // R3 app escape type 1
        '{2'd3, 1'b0, 1'b1, 3'b110, 3'd5, 2'd0, 3'd2, 3'd0}, // R4 full escape type 3
        '{2'd3, 1'b1, 1'b0, 3'b110, 3'd7, 2'd0, 3'd2, 3'd1}, // R4 app-only escape not enough
        '{2'd1, 1'b0, 1'b0, 3'b111, 3'd6, 2'd2, 3'd4, 3'd0}, // R6 masked-out bits differ
        '{2'd2, 1'b0, 1'b1, 3'b001, 3'd0, 2'd0, 3'd4, 3'd0}, // R7 type 2 ref increments
        '{2'd1, 1'b0, 1'b1, 3'b001, 3'd3, 2'd3, 3'd4, 3'd3}  // R7 R5 ref error on last block
    };

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R13 ready after reset", int'(in_ready), 0);
        chk(done == 1'b0, "R13 done after reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0 && done == 1'b0, "R13 idle before command", int'(in_ready), 0);

        for (int i = 0; i < 13; i++) begin
            run_cmd(VEC[i].pt, VEC[i].wd, VEC[i].te, VEC[i].ck, int'(VEC[i].bad),
                    int'(VEC[i].bblk), int'(VEC[i].nb), 1'b0, L0, VEC[i].est, 1'b0,
                    $sformatf("R11 vector %0d", i));
        end

        // R1: masked address mismatch on type 1
        run_cmd(2'd1, 1'b0, 1'b1, 3'b111, 0, 0, 2, 1'b0, L0 + 64'd1, 3'd4, 1'b1, "R1 lba mismatch 16-bit");
        run_cmd(2'd1, 1'b1, 1'b1, 3'b001, 0, 0, 2, 1'b0, L0 ^ 64'h0000_0100_0000_0000, 3'd4, 1'b1, "R1 lba mismatch 48-bit");
        // R1: type 2 makes no address comparison
        run_cmd(2'd2, 1'b0, 1'b1, 3'b111, 0, 0, 2, 1'b0, L0 + 64'd1, 3'd0, 1'b0, "R1 type 2 no precheck");
        // R2: type 3 with reference check requested
        run_cmd(2'd3, 1'b1, 1'b0, 3'b001, 0, 0, 2, 1'b0, L0, 3'd4, 1'b0, "R2 type 3 ref request");
        // R10: zero first block at address 0 in 64-bit format
        run_cmd(2'd1, 1'b1, 1'b0, 3'b100, 1, 0, 2, 1'b1, 64'h0, 3'd0, 1'b0, "R10 zero block forgiven");
        run_cmd(2'd1, 1'b1, 1'b0, 3'b100, 1, 0, 2, 1'b1, 64'h1, 3'd1, 1'b0, "R10 nonzero lba not forgiven");
        run_cmd(2'd1, 1'b0, 1'b0, 3'b100, 1, 0, 2, 1'b1, 64'h0, 3'd1, 1'b0, "R10 16-bit not forgiven");
        run_cmd(2'd1, 1'b1, 1'b0, 3'b100, 1, 1, 2, 1'b1, 64'h0, 3'd1, 1'b0, "R10 only first block");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule